// File: doc/BRIEF.md
# USB Root Hub Port Monitor

This block supervises the downstream root-hub ports of a full/low-speed USB host. For each port it takes already-synchronised samples of the two data lines and tracks whether a device is present. A device counts as attached only after one of its lines has stayed high for a debounce interval. It counts as detached only after both lines have stayed low for the same interval. At the moment of attach, the port records the level of its minus line. Software reads that bit to decide whether the device is low speed or full speed.

Each port holds a small control word with these fields:
- enable
- forced bus reset
- low-speed select
- receiver disable
- on the last port only, a pin-release bit

While a port drives bus reset, its attach and detach detection is frozen. The forced SE0 is therefore never mistaken for a disconnect. When a device leaves, hardware clears that port's enable by itself. A shared detect flag records every attach and detach on any port. Software clears the flag by writing 1, and the flag raises an interrupt only when its mask allows.

Top module: `hub_port_monitor`

## Requirements
- R1: After reset, every port reads not attached, disabled, full speed and not in bus reset, with its receiver disabled. The last port has its pin-release bit set, and the other ports read 0 for that bit. The detect flag and the interrupt are both 0.
- R2: Attach is declared on the clock edge that completes DEB consecutive samples in which either line is high. Any shorter run restarts the count. DEB is CLK_KHZ*25/10000 rounded up, with a minimum of 2, so it is 10 at CLK_KHZ=4000.
- R3: Detach is declared on the clock edge that completes DEB consecutive samples in which both lines are low. A high sample on either line restarts the count.
- R4: On the attach edge, the minus-line sample is stored in port_dm_at_attach. It keeps that value until the next attach.
- R5: The detach edge clears port_en on that same edge.
- R6: port_se0_drive follows the bus-reset field. While it is 1, that port neither attaches nor detaches, however long its lines stay low.
- R7: Every attach or detach on any port sets det_flag on that edge. A det_clr pulse clears det_flag. If an event and a clear fall on the same edge, the set wins.
- R8: det_irq is 1 exactly when both det_flag and det_ie are 1.
- R9: port_idle_ok is 1 when the port is enabled and its idle-high line is high. The idle-high line is the minus line when the low-speed field is 1, and the plus line otherwise.
- R10: Ports are independent. Line activity or a control write on one port leaves the status and control of every other port unchanged.
- R11: A pulse on ctl_we[i] loads port i from ctl_wdata. The bit positions are: bit0 enable, bit1 bus reset, bit2 low speed, bit3 receiver disable, bit4 pin release. Bit4 takes effect only on the last port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_dp | input | NUM_PORTS | Synchronised plus-line sample per port |
| line_dm | input | NUM_PORTS | Synchronised minus-line sample per port |
| ctl_we | input | NUM_PORTS | Per-port control write strobe |
| ctl_wdata | input | 5 | Control word shared by all ports |
| det_ie | input | 1 | Detect interrupt mask |
| det_clr | input | 1 | Write-1 clear of the detect flag |
| port_attached | output | NUM_PORTS | Debounced attach status |
| port_dm_at_attach | output | NUM_PORTS | Minus-line level captured at attach |
| port_en | output | NUM_PORTS | Port enable |
| port_ls | output | NUM_PORTS | Low-speed select |
| port_se0_drive | output | NUM_PORTS | Forced bus-reset request |
| port_rx_dis | output | NUM_PORTS | Receiver disable |
| port_pin_rel | output | NUM_PORTS | Pin release (last port only) |
| port_idle_ok | output | NUM_PORTS | Enabled port with its idle line high |
| det_flag | output | 1 | Connection change flag |
| det_irq | output | 1 | Masked interrupt request |

## Verification
The debounce is driven by a walked table of line patterns:
- high runs one cycle short of the threshold, which separates a glitch from an attach
- low gaps inside a high run, which show that the count restarts
- full-speed and low-speed idle levels, which show the captured minus-line bit telling the two speeds apart
- mixed line states while attached, which show the captured bit holding

Directed cases add the following:
- a long SE0 under forced reset, which tells suppression apart from a real detach
- detach while enabled, which shows the automatic enable clear
- a clear pulse coinciding with an event, which shows the set winning
- toggling the mask and the low-speed field, which selects the interrupt and the idle line
- activity on the second port, which confirms that the first port is left untouched

// File: rtl/hub_pkg.sv
package hub_pkg;

  localparam int CTL_W = 5;

  typedef struct packed {
    logic pin_rel;
    logic rx_dis;
    logic ls;
    logic bus_rst;
    logic en;
  } hub_ctl_t;

  function automatic int deb_cycles(input int clk_khz);
    int c;
    c = (clk_khz * 25 + 9999) / 10000;
    if (c < 2) c = 2;
    return c;
  endfunction

  function automatic logic idle_line(input logic ls, input logic dp, input logic dm);
    return ls ? dm : dp;
  endfunction

endpackage

// File: rtl/hub_debounce.sv
module hub_debounce #(
  parameter int DEB = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp,
  input  logic dm,
  input  logic suppress,
  output logic attached,
  output logic attach_evt,
  output logic detach_evt
);
  localparam int CW = $clog2(DEB + 1);

  logic [CW-1:0] cnt;
  logic          cond;
  logic          hit;

  always_comb begin
    cond       = attached ? !(dp | dm) : (dp | dm);
    hit        = cond && !suppress && (cnt == CW'(DEB - 1));
    attach_evt = hit && !attached;
    detach_evt = hit && attached;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      attached <= 1'b0;
    end else if (suppress || !cond) begin
      cnt <= '0;
    end else if (hit) begin
      cnt      <= '0;
      attached <= ~attached;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2 / R3: the run counter never passes the threshold
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(DEB));

endmodule

// File: rtl/hub_port_ctl.sv
module hub_port_ctl
  import hub_pkg::*;
#(
  parameter bit HAS_PIN_REL = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  hub_ctl_t wdata,
  input  logic     attach_evt,
  input  logic     detach_evt,
  input  logic     dp_now,
  input  logic     dm_now,
  output logic     en,
  output logic     ls,
  output logic     bus_rst,
  output logic     rx_dis,
  output logic     pin_rel,
  output logic     dm_lvl,
  output logic     idle_ok
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      ls      <= 1'b0;
      bus_rst <= 1'b0;
      rx_dis  <= 1'b1;
    end else begin
      if (we) begin
        ls      <= wdata.ls;
        bus_rst <= wdata.bus_rst;
        rx_dis  <= wdata.rx_dis;
      end
      if (detach_evt)  en <= 1'b0;
      else if (we)     en <= wdata.en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dm_lvl <= 1'b0;
    else if (attach_evt) dm_lvl <= dm_now;
  end

  generate
    if (HAS_PIN_REL) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  pin_rel <= 1'b1;
        else if (we) pin_rel <= wdata.pin_rel;
      end
    end else begin : g_nopin
      assign pin_rel = 1'b0;
    end
  endgenerate

  assign idle_ok = en & idle_line(ls, dp_now, dm_now);

  // R5: detach always leaves the port disabled
  a_r5_en_drop: assert property (@(posedge clk) disable iff (!rst_n)
    detach_evt |=> !en);

  // R4: the captured minus-line level changes only on an attach
  a_r4_dm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !attach_evt |=> $stable(dm_lvl));

endmodule

// File: rtl/hub_detect_flag.sv
module hub_detect_flag #(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] evt,
  input  logic                 clr,
  input  logic                 ie,
  output logic                 flag,
  output logic                 irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (|evt)  flag <= 1'b1;
    else if (clr)   flag <= 1'b0;
  end

  assign irq = flag & ie;

  // R7: any port event leaves the flag set
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> flag);

  // R7: a clear with no event empties the flag
  a_r7_flag_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(|evt)) |=> !flag);

endmodule

// File: rtl/hub_port_monitor.sv
module hub_port_monitor
  import hub_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int CLK_KHZ   = 48000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] line_dp,
  input  logic [NUM_PORTS-1:0] line_dm,
  input  logic [NUM_PORTS-1:0] ctl_we,
  input  logic [CTL_W-1:0]     ctl_wdata,
  input  logic                 det_ie,
  input  logic                 det_clr,
  output logic [NUM_PORTS-1:0] port_attached,
  output logic [NUM_PORTS-1:0] port_dm_at_attach,
  output logic [NUM_PORTS-1:0] port_en,
  output logic [NUM_PORTS-1:0] port_ls,
  output logic [NUM_PORTS-1:0] port_se0_drive,
  output logic [NUM_PORTS-1:0] port_rx_dis,
  output logic [NUM_PORTS-1:0] port_pin_rel,
  output logic [NUM_PORTS-1:0] port_idle_ok,
  output logic                 det_flag,
  output logic                 det_irq
);
  localparam int DEB = deb_cycles(CLK_KHZ);

  hub_ctl_t             wctl;
  logic [NUM_PORTS-1:0] attach_evt;
  logic [NUM_PORTS-1:0] detach_evt;
  logic [NUM_PORTS-1:0] any_evt;

  assign wctl    = hub_ctl_t'(ctl_wdata);
  assign any_evt = attach_evt | detach_evt;

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      hub_debounce #(.DEB(DEB)) u_deb (
        .clk        (clk),
        .rst_n      (rst_n),
        .dp         (line_dp[i]),
        .dm         (line_dm[i]),
        .suppress   (port_se0_drive[i]),
        .attached   (port_attached[i]),
        .attach_evt (attach_evt[i]),
        .detach_evt (detach_evt[i])
      );

      hub_port_ctl #(.HAS_PIN_REL((i == NUM_PORTS - 1) && (NUM_PORTS > 1))) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (ctl_we[i]),
        .wdata      (wctl),
        .attach_evt (attach_evt[i]),
        .detach_evt (detach_evt[i]),
        .dp_now     (line_dp[i]),
        .dm_now     (line_dm[i]),
        .en         (port_en[i]),
        .ls         (port_ls[i]),
        .bus_rst    (port_se0_drive[i]),
        .rx_dis     (port_rx_dis[i]),
        .pin_rel    (port_pin_rel[i]),
        .dm_lvl     (port_dm_at_attach[i]),
        .idle_ok    (port_idle_ok[i])
      );

      // R6: a port under forced reset keeps its attach state
      a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        port_se0_drive[i] |=> $stable(port_attached[i]));
    end
  endgenerate

  hub_detect_flag #(.NUM_PORTS(NUM_PORTS)) u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (any_evt),
    .clr   (det_clr),
    .ie    (det_ie),
    .flag  (det_flag),
    .irq   (det_irq)
  );

  // R8: no interrupt without a pending flag
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    det_irq |-> det_flag);

endmodule

// File: tb/hub_port_monitor_test.sv
module hub_port_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 2;
  localparam int DEB = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] line_dp = '0, line_dm = '0, ctl_we = '0;
  logic [4:0]    ctl_wdata = '0;
  logic          det_ie = 1'b0, det_clr = 1'b0;
  logic [NP-1:0] port_attached, port_dm_at_attach, port_en, port_ls;
  logic [NP-1:0] port_se0_drive, port_rx_dis, port_pin_rel, port_idle_ok;
  logic          det_flag, det_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hub_port_monitor #(.NUM_PORTS(NP), .CLK_KHZ(4000)) uut (
    .clk(clk), .rst_n(rst_n), .line_dp(line_dp), .line_dm(line_dm),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .det_ie(det_ie), .det_clr(det_clr),
    .port_attached(port_attached), .port_dm_at_attach(port_dm_at_attach),
    .port_en(port_en), .port_ls(port_ls), .port_se0_drive(port_se0_drive),
    .port_rx_dis(port_rx_dis), .port_pin_rel(port_pin_rel),
    .port_idle_ok(port_idle_ok), .det_flag(det_flag), .det_irq(det_irq)
  );

  // vector: dp, dm, hold cycles, expected attached, expected captured minus line
  typedef struct packed {
    logic       dp;
    logic       dm;
    logic [7:0] hold;
    logic       att;
    logic       dml;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b1, 1'b0, 8'd9,  1'b0, 1'b0},
    '{1'b0, 1'b0, 8'd3,  1'b0, 1'b0},
    '{1'b1, 1'b0, 8'd10, 1'b1, 1'b0},
    '{1'b0, 1'b0, 8'd9,  1'b1, 1'b0},
    '{1'b1, 1'b0, 8'd2,  1'b1, 1'b0},
    '{1'b0, 1'b0, 8'd10, 1'b0, 1'b0},
    '{1'b0, 1'b1, 8'd10, 1'b1, 1'b1},
    '{1'b1, 1'b1, 8'd5,  1'b1, 1'b1},
    '{1'b0, 1'b0, 8'd10, 1'b0, 1'b1}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // advance n edges; inputs change just after an edge, checks follow
  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input int p, input logic [4:0] d);
    ctl_wdata = d;
    ctl_we[p] = 1'b1;
    step(1);
    ctl_we[p] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(port_attached, 2'b00, "R1 attached");
    chk(port_en, 2'b00, "R1 enable");
    chk(port_se0_drive, 2'b00, "R1 bus reset");
    chk(port_rx_dis, 2'b11, "R1 rx disable");
    chk(port_pin_rel, 2'b10, "R1 pin release");
    chk({det_flag, det_irq}, 2'b00, "R1 flag/irq");

    // R2 R3 R4 table walk on port 0
    foreach (VECS[i]) begin
      line_dp[0] = VECS[i].dp;
      line_dm[0] = VECS[i].dm;
      step(int'(VECS[i].hold));
      chk(port_attached[0], VECS[i].att, $sformatf("R2/R3 vector %0d attached", i));
      chk(port_dm_at_attach[0], VECS[i].dml, $sformatf("R4 vector %0d captured", i));
    end
    chk(port_attached[1], 1'b0, "R10 port1 untouched by table");

    // R7 clear, R8 mask
    chk(det_flag, 1'b1, "R7 flag after events");
    chk(det_irq, 1'b0, "R8 masked");
    det_ie = 1'b1;
    #1;
    chk(det_irq, 1'b1, "R8 unmasked");
    det_clr = 1'b1;
    step(1);
    det_clr = 1'b0;
    chk(det_flag, 1'b0, "R7 cleared");
    chk(det_irq, 1'b0, "R8 no flag");

    // R11 R9: attach full speed on port 0, enable, switch speed select
    line_dp[0] = 1'b1;
    step(DEB);
    chk(port_attached[0], 1'b1, "R2 reattach");
    wr(0, 5'b00001);
    chk(port_en[0], 1'b1, "R11 enable written");
    chk(port_rx_dis[0], 1'b0, "R11 rx disable written");
    chk(port_idle_ok[0], 1'b1, "R9 plus line idle");
    wr(0, 5'b00101);
    chk(port_ls[0], 1'b1, "R11 low speed written");
    chk(port_idle_ok[0], 1'b0, "R9 minus line idle low");
    wr(0, 5'b10001);
    chk(port_pin_rel[0], 1'b0, "R11 pin release ignored on port0");
    chk(port_idle_ok[0], 1'b1, "R9 back to plus line");

    // R5: detach clears enable
    line_dp[0] = 1'b0;
    step(DEB - 1);
    chk(port_en[0], 1'b1, "R5 enable held before detach");
    step(1);
    chk(port_attached[0], 1'b0, "R3 detach");
    chk(port_en[0], 1'b0, "R5 enable cleared");

    // R10 R4: low speed device on port 1
    line_dm[1] = 1'b1;
    step(DEB);
    chk(port_attached[1], 1'b1, "R10 port1 attach");
    chk(port_dm_at_attach[1], 1'b1, "R4 port1 low speed");
    chk(port_attached[0], 1'b0, "R10 port0 unchanged");

    // R6: forced reset suppresses detach
    wr(1, 5'b00011);
    chk(port_se0_drive, 2'b10, "R6 drive on port1 only");
    chk(port_pin_rel[1], 1'b0, "R11 pin release cleared");
    line_dm[1] = 1'b0;
    step(3 * DEB);
    chk(port_attached[1], 1'b1, "R6 no detach under reset");
    wr(1, 5'b00001);
    chk(port_se0_drive[1], 1'b0, "R6 drive released");
    step(DEB - 1);
    chk(port_attached[1], 1'b1, "R6 count restarts after release");
    step(1);
    chk(port_attached[1], 1'b0, "R3 detach after release");
    chk(port_en[1], 1'b0, "R5 port1 enable cleared");

    // R7: set wins over simultaneous clear
    det_clr = 1'b1;
    step(1);
    chk(det_flag, 1'b0, "R7 cleared before event");
    line_dp[0] = 1'b1;
    step(DEB);
    chk(det_flag, 1'b1, "R7 set wins over clear");
    step(1);
    chk(det_flag, 1'b0, "R7 clear after event");
    det_clr = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule